// File: doc/BRIEF.md
# Dual-Mode Threshold Alert Comparator

This block watches a stream of signed 12-bit conversion results and drives a single alert pin. Each result comes with a one-cycle valid strobe. The block compares it with two programmable signed limits, one high and one low. The result of the comparison updates an internal alert state, and the pin shows that state at a selectable polarity.

A mode input picks one of two behaviours. In hysteresis mode, a result above the high limit raises the alert. The alert then stays raised until a result falls below the low limit, so results between the limits leave it as it is. In window mode there is no memory: every valid result raises the alert when it lies outside the inclusive band between the limits, and drops it when it lies inside. Changing the mode wipes the internal state, so evaluation restarts cleanly under the new rule.

Top module: `thr_alert_comparator`

## Requirements
- R1: While `rst` is high at a rising clock edge, the internal alert state becomes inactive, so from that edge the pin shows the inactive level: 1 when `pol_high`=0, and 0 when `pol_high`=1.
- R2: In hysteresis mode (`mode_win`=0), a valid result strictly greater than `lim_hi` makes the alert active from the clock edge that samples it. A result equal to `lim_hi` does not set the alert.
- R3: In hysteresis mode, the alert clears only on a valid result strictly less than `lim_lo`. A result inside the band, including one equal to either limit, leaves the alert unchanged.
- R4: In window mode (`mode_win`=1), each valid result sets the alert active when it is greater than `lim_hi` or less than `lim_lo`, and inactive when it lies in the inclusive band from `lim_lo` to `lim_hi`.
- R5: Results and limits are 12-bit two's complement, and every comparison is signed. For example, 12'h800 (-2048) is below 12'h801, and 12'hF00 (-256) is not above 12'h7FE.
- R6: In a cycle with `res_valid`=0 and no mode change, the alert state holds its value, whatever `res_data`, `lim_hi` or `lim_lo` carry.
- R7: `pol_high`=0 gives an active-low pin (active alert drives `alert_pin`=0). `pol_high`=1 gives an active-high pin. The pin follows `pol_high` without waiting for a clock edge.
- R8: When `mode_win` differs from its value at the previous clock edge, the alert state clears at that edge. A valid result sampled at that same edge is discarded. The next valid result is evaluated under the new mode.
- R9: In hysteresis mode, when `lim_hi` is below `lim_lo` and a result is both above `lim_hi` and below `lim_lo`, setting takes priority and the alert becomes active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Result strobe, one cycle per result |
| res_data | input | 12 | Conversion result, two's complement |
| lim_hi | input | 12 | Upper limit, two's complement |
| lim_lo | input | 12 | Lower limit, two's complement |
| mode_win | input | 1 | 0 = hysteresis, 1 = window |
| pol_high | input | 1 | 0 = active-low pin, 1 = active-high pin |
| alert_pin | output | 1 | Alert pin level |

## Verification
Some rules are checked on every cycle by the assertions:
- the state holds when no strobe arrives;
- a mode change clears the state;
- the window evaluation matches the limit flags;
- a set occurs above the high limit in hysteresis mode;
- in-band results leave the hysteresis state alone;
- the pin goes to the inactive level after reset.

Some behaviours can only be shown by the bench's scenarios:
- the exact boundary results, equal to each limit in each mode;
- signed ordering at the extremes of the 12-bit range;
- a result discarded in the same cycle as a mode switch;
- crossed limits;
- the combinational polarity flip.

// File: rtl/thr_alert_pkg.sv
package thr_alert_pkg;

    localparam int unsigned RES_W = 12;

    typedef enum logic {
        MODE_HYST = 1'b0,
        MODE_WIN  = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic above;
        logic below;
    } cmp_flags_t;

    // Next alert state for one valid result.
    function automatic logic next_alert(input cmp_mode_e mode,
                                        input cmp_flags_t fl,
                                        input logic cur);
        logic nxt;
        if (mode == MODE_WIN) begin
            nxt = fl.above | fl.below;
        end else if (fl.above) begin
            nxt = 1'b1;          // set wins when limits are crossed
        end else if (fl.below) begin
            nxt = 1'b0;
        end else begin
            nxt = cur;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/thr_alert_cmp.sv
module thr_alert_cmp
    import thr_alert_pkg::*;
#(
    parameter int unsigned W = RES_W
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] upper,
    input  logic [W-1:0] lower,
    output cmp_flags_t   flags
);
    logic signed [W-1:0] v_s, u_s, l_s;

    always_comb begin
        v_s         = $signed(value);
        u_s         = $signed(upper);
        l_s         = $signed(lower);
        flags.above = (v_s > u_s);
        flags.below = (v_s < l_s);
    end
endmodule

// File: rtl/thr_alert_core.sv
module thr_alert_core
    import thr_alert_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  cmp_mode_e  mode,
    input  cmp_flags_t flags,
    output logic       active
);
    cmp_mode_e mode_q;
    logic      mode_chg;

    assign mode_chg = (mode != mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            mode_q <= mode;
        end else begin
            mode_q <= mode;
            if (mode_chg) begin
                active <= 1'b0;
            end else if (valid) begin
                active <= next_alert(mode, flags, active);
            end
        end
    end

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!valid && !mode_chg) |=> $stable(active));

    assert_mode_clear_R8: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> !active);

    assert_window_eval_R4: assert property (@(posedge clk) disable iff (rst)
        (valid && !mode_chg && mode == MODE_WIN)
        |=> (active == ($past(flags.above) || $past(flags.below))));

    assert_hyst_set_R2: assert property (@(posedge clk) disable iff (rst)
        (valid && !mode_chg && mode == MODE_HYST && flags.above) |=> active);

    assert_hyst_band_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (valid && !mode_chg && mode == MODE_HYST && !flags.above && !flags.below)
        |=> $stable(active));
endmodule

// File: rtl/thr_alert_drive.sv
module thr_alert_drive (
    input  logic active,
    input  logic pol_high,
    output logic pin
);
    always_comb begin
        if (pol_high) pin = active;
        else          pin = ~active;
    end
endmodule

// File: rtl/thr_alert_comparator.sv
module thr_alert_comparator
    import thr_alert_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    input  logic [RES_W-1:0] lim_hi,
    input  logic [RES_W-1:0] lim_lo,
    input  logic             mode_win,
    input  logic             pol_high,
    output logic             alert_pin
);
    cmp_flags_t flags;
    logic       active;
    cmp_mode_e  mode;

    assign mode = cmp_mode_e'(mode_win);

    thr_alert_cmp #(.W(RES_W)) i_cmp (
        .value (res_data),
        .upper (lim_hi),
        .lower (lim_lo),
        .flags (flags)
    );

    thr_alert_core i_core (
        .clk    (clk),
        .rst    (rst),
        .valid  (res_valid),
        .mode   (mode),
        .flags  (flags),
        .active (active)
    );

    thr_alert_drive i_drive (
        .active   (active),
        .pol_high (pol_high),
        .pin      (alert_pin)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (alert_pin == !pol_high));
endmodule

// File: tb/test_thr_alert_comparator.sv
`timescale 1ns/1ps
module test_thr_alert_comparator;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic [11:0] lim_hi = 12'sd100;
    logic [11:0] lim_lo = -12'sd100;
    logic        mode_win = 1'b0;
    logic        pol_high = 1'b0;
    logic        alert_pin;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    thr_alert_comparator i_thr_alert_comparator (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .mode_win(mode_win),
        .pol_high(pol_high), .alert_pin(alert_pin)
    );

    task automatic check(input string req, input logic exp_pin);
        n_run++;
        if (alert_pin !== exp_pin) begin
            n_fail++;
            $display("FAIL %s: alert_pin=%b expected %b at %0t", req, alert_pin, exp_pin, $time);
        end
    endtask

    task automatic apply(input logic [11:0] v, input string req, input logic exp_pin);
        @(negedge clk);
        res_valid = 1'b1;
        res_data  = v;
        @(posedge clk);
        #1;
        res_valid = 1'b0;
        check(req, exp_pin);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(2);
        check("R1", 1'b1);
        @(negedge clk);
        rst = 1'b0;
        idle(1);
        check("R1", 1'b1);
    endtask

    task automatic t_hyst;
        apply(12'sd50,   "R2", 1'b1);
        apply(12'sd100,  "R2", 1'b1);  // equal to high limit: no set
        apply(12'sd101,  "R2", 1'b0);
        apply(12'sd0,    "R3", 1'b0);
        apply(-12'sd100, "R3", 1'b0);  // equal to low limit: hold
        apply(-12'sd101, "R3", 1'b1);
    endtask

    task automatic t_hold;
        apply(12'sd200, "R6", 1'b0);
        @(negedge clk);
        res_data = -12'sd500;
        idle(3);
        check("R6", 1'b0);
        @(negedge clk);
        lim_hi = 12'sd1000;
        lim_lo = 12'sd900;
        idle(2);
        check("R6", 1'b0);
        @(negedge clk);
        lim_hi = 12'sd100;
        lim_lo = -12'sd100;
        apply(-12'sd500, "R6", 1'b1);
    endtask

    task automatic t_window;
        apply(12'sd200, "R8", 1'b0);    // set in hysteresis first
        @(negedge clk);
        mode_win = 1'b1;
        idle(1);
        check("R8", 1'b1);              // switch cleared it
        apply(12'sd150,  "R4", 1'b0);
        apply(12'sd50,   "R4", 1'b1);
        apply(-12'sd150, "R4", 1'b0);
        apply(-12'sd100, "R4", 1'b1);   // inclusive low edge
        apply(12'sd150,  "R4", 1'b0);
        apply(12'sd100,  "R4", 1'b1);   // inclusive high edge
        apply(12'sd101,  "R4", 1'b0);
    endtask

    task automatic t_mode_switch;
        // alert active in window mode; switch with a valid above-limit result
        @(negedge clk);
        mode_win  = 1'b0;
        res_valid = 1'b1;
        res_data  = 12'sd500;
        @(posedge clk);
        #1;
        res_valid = 1'b0;
        check("R8", 1'b1);              // cleared, result discarded
        apply(12'sd50,  "R8", 1'b1);    // in band under hysteresis: stays clear
        apply(12'sd500, "R8", 1'b0);
        @(negedge clk);
        mode_win = 1'b1;
        idle(1);
        check("R8", 1'b1);
        @(negedge clk);
        mode_win = 1'b0;
        idle(1);
        check("R8", 1'b1);
    endtask

    task automatic t_signed;
        @(negedge clk);
        lim_hi = 12'h7FE;
        lim_lo = 12'h801;
        apply(12'hF00, "R5", 1'b1);     // -256 not above 2046
        apply(12'h7FF, "R5", 1'b0);
        apply(12'h801, "R5", 1'b0);     // equal to low: hold
        apply(12'h800, "R5", 1'b1);     // -2048 below -2047
    endtask

    task automatic t_crossed;
        @(negedge clk);
        lim_hi = -12'sd50;
        lim_lo = 12'sd50;
        apply(12'sd0,   "R9", 1'b0);
        apply(12'sd60,  "R9", 1'b0);
        apply(-12'sd60, "R9", 1'b1);
    endtask

    task automatic t_polarity;
        @(negedge clk);
        lim_hi = 12'sd100;
        lim_lo = -12'sd100;
        pol_high = 1'b1;
        #1;
        check("R7", 1'b0);
        apply(12'sd200, "R7", 1'b1);
        @(negedge clk);
        pol_high = 1'b0;
        #1;
        check("R7", 1'b0);
        // reset while active, active-high polarity
        @(negedge clk);
        pol_high = 1'b1;
        rst = 1'b1;
        idle(1);
        check("R1", 1'b0);
        @(negedge clk);
        rst = 1'b0;
        pol_high = 1'b0;
        #1;
        check("R1", 1'b1);
    endtask

    initial begin
        t_reset();
        t_hyst();
        t_hold();
        t_window();
        t_mode_switch();
        t_signed();
        t_crossed();
        t_polarity();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule